// File: doc/BRIEF.md
# Watchdog Timer with Shared Divider

This block is a watchdog that runs on its own free-running clock, `wd_clk`, so it keeps counting while the core clock is stopped during sleep. A base counter produces one tick every `BASE_CNT` watchdog cycles. A single power-of-two divider is shared with a general-purpose timer. When `div_to_wdog` is 1, the divider sits behind the base counter and stretches the watchdog timeout. When `div_to_wdog` is 0, the divider serves the timer: it divides the incoming timer ticks, and the watchdog times out on the bare base period.

A timeout raises `reset_req` when the device is awake and `wake_req` when it is asleep, and it drives `timeout_n` low. Firmware keeps the watchdog quiet with a clear strobe. The sleep-entry strobe has the same restarting effect. Both strobes come from the core clock domain and cross into the watchdog domain through a toggle synchronizer. The sleep flag is synchronized with a two-stage chain. `cfg_en`, `div_to_wdog` and `div_sel` are configuration inputs. They are expected to hold steady, and a clear strobe follows any change.

A controller with four states decides the outputs:
- `WD_OFF`: disabled.
- `WD_COUNT`: counting.
- `WD_RESET`: one cycle of reset request.
- `WD_WAKE`: one cycle of wake request.

Its transitions are:
- OFF→COUNT when `cfg_en` rises.
- Any state→OFF when `cfg_en` is low.
- COUNT/RESET/WAKE→RESET on an awake expiry.
- COUNT/RESET/WAKE→WAKE on an asleep expiry.
- RESET/WAKE→COUNT when there is no new expiry.

Top module: `wdog_shared_div`

## Requirements
- R1: After reset, `reset_req` and `wake_req` are 0 and `timeout_n` is 1.
- R2: While `cfg_en` is 0, no request is ever raised and `timeout_n` stays 1.
- R3: With `div_to_wdog`=0 and the device awake, `reset_req` pulses for one cycle every `BASE_CNT` watchdog cycles, whatever the value of `div_sel`.
- R4: With `div_to_wdog`=1, successive requests are `BASE_CNT * 2^div_sel` watchdog cycles apart (`div_sel` 0..7 gives 1:1 to 1:128).
- R5: A timeout while `sleep_mode`=1 raises `wake_req` instead of `reset_req`. The two requests are never high together.
- R6: A timeout drives `timeout_n` to 0. A clear strobe or a sleep-entry strobe sets it back to 1.
- R7: A clear strobe restarts the base counter and, when `div_to_wdog`=1, the divider count. Clears spaced shorter than one period keep every request away.
- R8: A sleep-entry strobe restarts the counters exactly as a clear strobe does.
- R9: With `div_to_wdog`=0, `gt_tick_out` pulses on every `2^div_sel`-th `gt_tick`. A clear strobe does not reset that count.
- R10: With `div_to_wdog`=1, `gt_tick_out` follows `gt_tick` undivided.
- R11: A single one-core-cycle strobe acts once. The next timeout then follows the full period, plus a synchronizer latency of two to three watchdog cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock, source domain of the strobes |
| core_rst_n | input | 1 | Core domain reset, active low |
| wd_clk | input | 1 | Free-running watchdog clock |
| wd_rst_n | input | 1 | Watchdog domain reset, active low |
| clr_stb | input | 1 | Clear strobe, one core cycle |
| sleep_stb | input | 1 | Sleep-entry strobe, one core cycle |
| sleep_mode | input | 1 | Device asleep flag (core domain) |
| cfg_en | input | 1 | Configuration enable for the watchdog |
| div_to_wdog | input | 1 | 1: divider serves watchdog; 0: divider serves timer |
| div_sel | input | 3 | Divider ratio exponent n, ratio 2^n |
| gt_tick | input | 1 | General timer tick, one `wd_clk` cycle |
| gt_tick_out | output | 1 | Tick passed to the general timer |
| reset_req | output | 1 | Device reset request pulse |
| wake_req | output | 1 | Wake-up request pulse |
| timeout_n | output | 1 | Low after a timeout |

## Verification
The bench measures exact spacing between successive requests at the ratios 1:1, 1:8 and 1:128, and with the divider handed to the timer. A wrong shift amount, or a watchdog that keeps using the divider after handing it over, shows up as a wrong interval. It issues clears faster than the period with ratio 1:4. A design that restarts only the base counter lets the divider creep upward and fires a reset. In timer mode it issues a clear between divided ticks. A design that wipes the divider there delays `gt_tick_out` by a full ratio. Sleep checks confirm a wake request with no reset request. Disabled checks confirm silence over many periods.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_COUNT = 2'd1,
        WD_RESET = 2'd2,
        WD_WAKE  = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdog_pulse_sync.sv
// Toggle synchronizer: one source-cycle strobe becomes one destination-cycle pulse.
module wdog_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic             src_tog;
    logic [STAGES:0]  chain;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n)     src_tog <= 1'b0;
        else if (src_pulse) src_tog <= ~src_tog;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) chain[0] <= 1'b0;
        else            chain[0] <= src_tog;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge dst_clk or negedge dst_rst_n) begin
            if (!dst_rst_n) chain[g] <= 1'b0;
            else            chain[g] <= chain[g-1];
        end
    end

    assign dst_pulse = chain[STAGES] ^ chain[STAGES-1];

    // R11: each strobe yields a single destination pulse
    p_single_pulse_r11: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);
endmodule

// File: rtl/wdog_base.sv
// Base period counter: one tick every BASE_CNT cycles while running.
module wdog_base #(
    parameter int BASE_CNT = 18000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CW = (BASE_CNT > 2) ? $clog2(BASE_CNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE_CNT - 1);

    logic [CW-1:0] cnt;

    assign tick = run && !clear && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clear || !run)  cnt <= '0;
        else if (cnt == LAST)    cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // R3: count never passes the last value of the period
    p_base_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R7: a clear restarts the period
    p_base_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/wdog_div.sv
// Shared power-of-two divider: hit on every 2^sel-th step.
module wdog_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] mask;

    always_comb begin
        span = ({{CNT_W{1'b0}}, 1'b1} << sel) - 1'b1;
        mask = span[CNT_W-1:0];
    end

    assign hit = step && !clear && (cnt == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (hit)    cnt <= '0;
        else if (step)   cnt <= cnt + 1'b1;
    end

    // R7: clearing the divider empties its count
    p_div_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
    // R9: with no step the count holds
    p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(cnt));
endmodule

// File: rtl/wdog_shared_div.sv
module wdog_shared_div
    import wdog_pkg::*;
#(
    parameter int BASE_CNT    = 18000,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             core_clk,
    input  logic             core_rst_n,
    input  logic             wd_clk,
    input  logic             wd_rst_n,
    input  logic             clr_stb,
    input  logic             sleep_stb,
    input  logic             sleep_mode,
    input  logic             cfg_en,
    input  logic             div_to_wdog,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             gt_tick,
    output logic             gt_tick_out,
    output logic             reset_req,
    output logic             wake_req,
    output logic             timeout_n
);
    wd_state_e state, state_nxt;

    logic                   clr_p, slp_p, restart;
    logic [SYNC_STAGES-1:0] sleep_chain;
    logic                   sleep_s;
    logic                   base_tick, div_hit, div_step, div_clear, expire;

    wdog_pulse_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .src_clk(core_clk), .src_rst_n(core_rst_n), .src_pulse(clr_stb),
        .dst_clk(wd_clk),   .dst_rst_n(wd_rst_n),   .dst_pulse(clr_p)
    );

    wdog_pulse_sync #(.STAGES(SYNC_STAGES)) u_slp_sync (
        .src_clk(core_clk), .src_rst_n(core_rst_n), .src_pulse(sleep_stb),
        .dst_clk(wd_clk),   .dst_rst_n(wd_rst_n),   .dst_pulse(slp_p)
    );

    always_ff @(posedge wd_clk or negedge wd_rst_n) begin
        if (!wd_rst_n) sleep_chain <= '0;
        else           sleep_chain <= {sleep_chain[SYNC_STAGES-2:0], sleep_mode};
    end
    assign sleep_s = sleep_chain[SYNC_STAGES-1];

    assign restart = clr_p | slp_p;

    wdog_base #(.BASE_CNT(BASE_CNT)) u_base (
        .clk(wd_clk), .rst_n(wd_rst_n), .run(cfg_en),
        .clear(restart), .tick(base_tick)
    );

    // Divider input: base ticks for the watchdog, timer ticks otherwise
    assign div_step  = div_to_wdog ? base_tick : gt_tick;
    assign div_clear = div_to_wdog && (restart || !cfg_en);

    wdog_div #(.SEL_W(SEL_W)) u_div (
        .clk(wd_clk), .rst_n(wd_rst_n), .clear(div_clear),
        .step(div_step), .sel(div_sel), .hit(div_hit)
    );

    assign gt_tick_out = div_to_wdog ? gt_tick : div_hit;
    assign expire      = cfg_en && !restart && (div_to_wdog ? div_hit : base_tick);

    // State register
    always_ff @(posedge wd_clk or negedge wd_rst_n) begin
        if (!wd_rst_n) state <= WD_OFF;
        else           state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            WD_OFF: begin
                if (cfg_en) state_nxt = WD_COUNT;
            end
            WD_COUNT, WD_RESET, WD_WAKE: begin
                if (!cfg_en)     state_nxt = WD_OFF;
                else if (expire) state_nxt = sleep_s ? WD_WAKE : WD_RESET;
                else             state_nxt = WD_COUNT;
            end
            default: state_nxt = WD_OFF;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        reset_req = 1'b0;
        wake_req  = 1'b0;
        unique case (state)
            WD_RESET: reset_req = 1'b1;
            WD_WAKE:  wake_req  = 1'b1;
            default: ;
        endcase
    end

    // Timeout status flag
    always_ff @(posedge wd_clk or negedge wd_rst_n) begin
        if (!wd_rst_n)    timeout_n <= 1'b1;
        else if (restart) timeout_n <= 1'b1;
        else if (expire)  timeout_n <= 1'b0;
    end

    // R5: never both requests at once
    p_req_excl_r5: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        $onehot0({reset_req, wake_req}));
    // R5: a wake request only follows an asleep expiry
    p_wake_asleep_r5: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        $rose(wake_req) |-> $past(sleep_s));
    // R2: disabled watchdog stays silent
    p_off_silent_r2: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        !cfg_en |=> (!reset_req && !wake_req));
    // R6: any request is accompanied by a low status flag
    p_flag_low_r6: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        (reset_req || wake_req) |-> !timeout_n);
endmodule

// File: tb/wdog_shared_div_bench.sv
module wdog_shared_div_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int CORE_PERIOD = 7;
    localparam int BASE        = 8;

    logic core_clk = 1'b0, wd_clk = 1'b0;
    logic core_rst_n = 1'b0, wd_rst_n = 1'b0;
    logic clr_stb = 1'b0, sleep_stb = 1'b0, sleep_mode = 1'b0;
    logic cfg_en = 1'b0, div_to_wdog = 1'b0, gt_tick = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic gt_tick_out, reset_req, wake_req, timeout_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2)  wd_clk   = ~wd_clk;
    always #(CORE_PERIOD/2) core_clk = ~core_clk;

    wdog_shared_div #(.BASE_CNT(BASE), .SEL_W(3), .SYNC_STAGES(2)) u_wdog_shared_div (
        .core_clk(core_clk), .core_rst_n(core_rst_n), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
        .clr_stb(clr_stb), .sleep_stb(sleep_stb), .sleep_mode(sleep_mode),
        .cfg_en(cfg_en), .div_to_wdog(div_to_wdog), .div_sel(div_sel),
        .gt_tick(gt_tick), .gt_tick_out(gt_tick_out),
        .reset_req(reset_req), .wake_req(wake_req), .timeout_n(timeout_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input bit en, input bit to_wd, input int sel);
        @(posedge wd_clk); #1;
        cfg_en = en; div_to_wdog = to_wd; div_sel = 3'(sel);
    endtask

    task automatic pulse_clr();
        @(negedge core_clk); clr_stb = 1'b1;
        @(negedge core_clk); clr_stb = 1'b0;
    endtask

    task automatic pulse_slp();
        @(negedge core_clk); sleep_stb = 1'b1;
        @(negedge core_clk); sleep_stb = 1'b0;
    endtask

    task automatic wait_req(input int limit, output int cyc, output bit rst, output bit wk);
        cyc = -1; rst = 1'b0; wk = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge wd_clk);
            if (reset_req || wake_req) begin
                cyc = i + 1; rst = reset_req; wk = wake_req;
                break;
            end
        end
    endtask

    task automatic watch(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge wd_clk);
            if (reset_req || wake_req) hits++;
        end
    endtask

    task automatic gt_pulse(output bit seen);
        @(posedge wd_clk); #1 gt_tick = 1'b1;
        @(negedge wd_clk); seen = gt_tick_out;
        @(posedge wd_clk); #1 gt_tick = 1'b0;
        repeat (2) @(negedge wd_clk);
    endtask

    task automatic measure(input string req, input int sel, input bit to_wd, input int exp);
        int c; bit r, w;
        set_cfg(1'b1, to_wd, sel);
        pulse_clr();
        wait_req(3000, c, r, w);
        wait_req(3000, c, r, w);
        check(c == exp, req, "request interval", c, exp);
        check(r && !w, req, "reset request kind", int'(r), 1);
    endtask

    task automatic t_reset();
        @(negedge wd_clk);
        check(!reset_req, "R1", "reset_req after reset", int'(reset_req), 0);
        check(!wake_req,  "R1", "wake_req after reset",  int'(wake_req), 0);
        check(timeout_n,  "R1", "timeout_n after reset", int'(timeout_n), 1);
    endtask

    task automatic t_disabled();
        int h;
        set_cfg(1'b0, 1'b0, 0);
        watch(600, h);
        check(h == 0, "R2", "requests while disabled", h, 0);
        check(timeout_n, "R2", "timeout_n while disabled", int'(timeout_n), 1);
    endtask

    task automatic t_unassigned();
        measure("R3", 5, 1'b0, BASE);
        check(!timeout_n, "R6", "timeout_n after timeout", int'(timeout_n), 0);
    endtask

    task automatic t_assigned();
        measure("R4", 0, 1'b1, BASE);
        measure("R4", 3, 1'b1, BASE * 8);
        measure("R4", 7, 1'b1, BASE * 128);
    endtask

    task automatic t_sleep();
        int c; bit r, w;
        @(negedge core_clk); sleep_mode = 1'b1;
        set_cfg(1'b1, 1'b1, 1);
        pulse_clr();
        wait_req(500, c, r, w);
        wait_req(500, c, r, w);
        check(w && !r, "R5", "wake request while asleep", int'(w), 1);
        check(c == BASE * 2, "R5", "wake interval", c, BASE * 2);
        @(negedge core_clk); sleep_mode = 1'b0;
        repeat (4) @(negedge wd_clk);
    endtask

    task automatic t_clear_hold();
        int h, tot;
        set_cfg(1'b1, 1'b1, 2);
        wait_req(500, h, tot[0], tot[1]);
        check(!timeout_n, "R6", "timeout_n low before clear", int'(timeout_n), 0);
        tot = 0;
        for (int k = 0; k < 15; k++) begin
            pulse_clr();
            watch(18, h);
            tot += h;
            if (k == 0) check(timeout_n, "R6", "timeout_n after clear", int'(timeout_n), 1);
        end
        check(tot == 0, "R7", "requests under periodic clear", tot, 0);
    endtask

    task automatic t_sleep_strobe_hold();
        int h, tot;
        bit r, w;
        set_cfg(1'b1, 1'b1, 2);
        wait_req(500, h, r, w);
        tot = 0;
        for (int k = 0; k < 15; k++) begin
            pulse_slp();
            watch(18, h);
            tot += h;
            if (k == 0) check(timeout_n, "R6", "timeout_n after sleep strobe", int'(timeout_n), 1);
        end
        check(tot == 0, "R8", "requests under periodic sleep strobe", tot, 0);
    endtask

    task automatic t_latency();
        int c; bit r, w;
        set_cfg(1'b1, 1'b1, 2);
        pulse_clr();
        wait_req(200, c, r, w);
        check(c >= BASE * 4 - 3 && c <= BASE * 4 + 4, "R11",
              "cycles from single clear to timeout", c, BASE * 4);
    endtask

    task automatic t_gt_div();
        bit s;
        int n;
        set_cfg(1'b1, 1'b0, 2);
        for (int k = 0; k < 8; k++) begin
            gt_pulse(s);
            if (s) break;
        end
        n = 0;
        for (int k = 0; k < 12; k++) begin
            gt_pulse(s);
            if (s) n++;
        end
        check(n == 3, "R9", "divided timer ticks out of 12", n, 3);
        gt_pulse(s);
        gt_pulse(s);
        pulse_clr();
        repeat (6) @(negedge wd_clk);
        gt_pulse(s);
        check(!s, "R9", "third tick after clear", int'(s), 0);
        gt_pulse(s);
        check(s, "R9", "fourth tick despite clear", int'(s), 1);
    endtask

    task automatic t_gt_pass();
        bit s;
        int n = 0;
        set_cfg(1'b1, 1'b1, 4);
        for (int k = 0; k < 5; k++) begin
            gt_pulse(s);
            if (s) n++;
        end
        check(n == 5, "R10", "undivided timer ticks", n, 5);
    endtask

    initial begin
        repeat (150000) @(posedge wd_clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge wd_clk);
        #1; core_rst_n = 1'b1; wd_rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_unassigned();
        t_assigned();
        t_sleep();
        t_clear_hold();
        t_sleep_strobe_hold();
        t_latency();
        t_gt_div();
        t_gt_pass();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule